// File: doc/BRIEF.md
# DS3 Receive Payload Output Interface

This block sits behind a DS3 receive framer that has already located frame alignment. It takes the recovered line bit stream, one bit per line clock, together with a frame-start reference, and hands the traffic to terminal equipment in one of two formats. In serial format every line bit is passed through, the 56 overhead positions of each 4760-bit M-frame are flagged so the receiver can discard them, and a one-bit-period mark identifies the first bit of each frame. In nibble format the overhead bits are dropped and the 4704 payload bits are packed into 1176 four-bit words. Each word is announced by a single pulse on a gated nibble clock. The mark spans the period in which the first word of the frame is presented.

An internal position counter follows the 85-bit block and 56-block frame structure. It wraps on its own and realigns to bit 0 whenever the frame-start reference arrives. A mode-select input is sampled only at frame boundaries, so a frame is never split between formats. The data flow runs at line rate and has no back-pressure. The receiver must accept every bit or nibble when it is presented, because the line cannot be stalled. For that reason no valid/ready handshake is provided.

The block clock is the receive line clock, and in serial format it also serves as the output clock. Every output is registered on its rising edge, one clock after the input bit is presented.

Top module: `ds3po_rx_out`

## Requirements
- R1: In serial mode, `ser_data` equals the `rx_bit` value from one clock earlier, for every frame position including overhead.
- R2: In serial mode, `ser_ovh` is 1 exactly when `ser_data` carries a frame position whose index modulo 85 is 0 (the first bit of each 85-bit block), and 0 otherwise.
- R3: In serial mode, `frame_mark` is high for exactly one clock, when `ser_data` carries frame position 0.
- R4: In nibble mode, overhead bits are discarded and the payload bits of each block are packed four at a time into `nib_data`, with the earliest received bit in bit 3 and the latest in bit 0.
- R5: In nibble mode, `nib_clk` goes high for one clock, one clock after a new `nib_data` value is loaded, while `nib_data` holds that value. It pulses exactly 1176 times per 4760-clock frame, and never during overhead-only stretches.
- R6: In nibble mode, `frame_mark` rises together with the load of the first nibble of a frame and stays high until the next nibble is loaded.
- R7: `mode_sel` (0 = serial, 1 = nibble) is sampled only at frame position 0. A change in mid-frame has no effect on any output until the next frame boundary.
- R8: Synchronous active-high `rst` drives all outputs to 0. After reset, all outputs stay 0 and no `nib_clk` pulse occurs until the first `rx_frame_start`.
- R9: A 1 on `rx_frame_start` marks the current `rx_bit` as frame position 0, whatever position the counter expected.
- R10: Without `rx_frame_start`, the position counter wraps by itself after 4760 bits, giving a frame period of 4760 clocks.
- R11: The outputs of the unselected format are held at 0. The one exception is the last nibble of a nibble-mode frame, which keeps its `nib_data` value and still gets its `nib_clk` pulse after a switch to serial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive line clock; serial output clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | Output format request: 0 serial, 1 nibble |
| rx_bit | input | 1 | Recovered, frame-aligned line bit |
| rx_frame_start | input | 1 | High with the bit at frame position 0 |
| ser_data | output | 1 | Serial data output |
| ser_ovh | output | 1 | Overhead flag for the bit on `ser_data` |
| nib_data | output | 4 | Packed payload nibble |
| nib_clk | output | 1 | Gated nibble clock, one pulse per nibble |
| frame_mark | output | 1 | First bit or first nibble of a frame |

## Verification
The assertions assume that `rst` is high from time zero and that `mode_sel`, `rx_bit` and `rx_frame_start` are never unknown. The nibble-spacing property also assumes the nibble width divides the 84 payload bits of a block, so that no nibble straddles an overhead bit. The bench drives all inputs on the falling edge from a seeded random source. It holds `rx_frame_start` back right after reset, raises it at frame position 0 or at a few chosen mid-frame positions, and at times leaves it off so the counter runs free. It changes `mode_sel` only in mid-frame, which exercises the boundary rule.

// File: rtl/ds3po_pkg.sv
package ds3po_pkg;
  typedef enum logic {
    FMT_SERIAL = 1'b0,
    FMT_NIBBLE = 1'b1
  } out_fmt_e;
endpackage

// File: rtl/ds3po_frame_pos.sv
// Tracks the bit position inside the M-frame as (bit-in-block, block).
module ds3po_frame_pos #(
  parameter int BLOCK_LEN = 85,
  parameter int BLOCKS    = 56
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  output logic active,
  output logic at_ovh,
  output logic at_start
);
  localparam int BW = $clog2(BLOCK_LEN);
  localparam int KW = $clog2(BLOCKS);
  localparam logic [BW-1:0] BIT_LAST = BW'(BLOCK_LEN - 1);
  localparam logic [KW-1:0] BLK_LAST = KW'(BLOCKS - 1);

  logic [BW-1:0] bit_q, bit_cur;
  logic [KW-1:0] blk_q, blk_cur;
  logic          sync_q;

  // A frame-start pulse overrides the expected position.
  assign bit_cur  = frame_start ? '0 : bit_q;
  assign blk_cur  = frame_start ? '0 : blk_q;
  assign active   = sync_q | frame_start;
  assign at_ovh   = active && (bit_cur == '0);
  assign at_start = at_ovh && (blk_cur == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q  <= '0;
      blk_q  <= '0;
      sync_q <= 1'b0;
    end else if (active) begin
      sync_q <= 1'b1;
      if (bit_cur == BIT_LAST) begin
        bit_q <= '0;
        blk_q <= (blk_cur == BLK_LAST) ? '0 : blk_cur + 1'b1;
      end else begin
        bit_q <= bit_cur + 1'b1;
        blk_q <= blk_cur;
      end
    end
  end
endmodule

// File: rtl/ds3po_serial_path.sv
// Registered pass-through of line bits with overhead and frame flags.
module ds3po_serial_path (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic fmt_nib,
  input  logic at_ovh,
  input  logic at_start,
  input  logic din,
  output logic ser_data,
  output logic ser_ovh,
  output logic ser_frm
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ser_data <= 1'b0;
      ser_ovh  <= 1'b0;
      ser_frm  <= 1'b0;
    end else if (active) begin
      ser_data <= !fmt_nib && din;
      ser_ovh  <= !fmt_nib && at_ovh;
      ser_frm  <= !fmt_nib && at_start;
    end
  end
endmodule

// File: rtl/ds3po_nibble_pack.sv
// Drops overhead bits, packs payload MSB-first and issues one clock pulse
// per packed word, one cycle after the word is loaded.
module ds3po_nibble_pack #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             fmt_nib,
  input  logic             at_ovh,
  input  logic             at_start,
  input  logic             din,
  output logic [NIB_W-1:0] nib_data,
  output logic             nib_clk,
  output logic             nib_frm
);
  localparam int PW = $clog2(NIB_W);
  localparam logic [PW-1:0] PH_LAST = PW'(NIB_W - 1);

  logic [NIB_W-2:0] shf_q;
  logic [PW-1:0]    ph_q;
  logic             first_q;
  logic             pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shf_q    <= '0;
      ph_q     <= '0;
      first_q  <= 1'b0;
      pend_q   <= 1'b0;
      nib_data <= '0;
      nib_clk  <= 1'b0;
      nib_frm  <= 1'b0;
    end else if (active) begin
      nib_clk <= pend_q;
      pend_q  <= 1'b0;
      if (fmt_nib) begin
        if (at_ovh) begin
          ph_q <= '0;
          if (at_start) first_q <= 1'b1;
        end else begin
          shf_q <= {shf_q[NIB_W-3:0], din};
          if (ph_q == PH_LAST) begin
            nib_data <= {shf_q, din};
            pend_q   <= 1'b1;
            nib_frm  <= first_q;
            first_q  <= 1'b0;
            ph_q     <= '0;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
      end else begin
        nib_frm <= 1'b0;
        // Keep a just-loaded word until its pulse has been issued.
        if (!pend_q) nib_data <= '0;
      end
    end
  end
endmodule

// File: rtl/ds3po_rx_out.sv
module ds3po_rx_out #(
  parameter int BLOCK_LEN = 85,
  parameter int BLOCKS    = 56,
  parameter int NIB_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_sel,
  input  logic             rx_bit,
  input  logic             rx_frame_start,
  output logic             ser_data,
  output logic             ser_ovh,
  output logic [NIB_W-1:0] nib_data,
  output logic             nib_clk,
  output logic             frame_mark
);
  import ds3po_pkg::*;

  logic     active, at_ovh, at_start;
  logic     ser_frm, nib_frm;
  out_fmt_e mode_q, fmt_now;

  ds3po_frame_pos #(.BLOCK_LEN(BLOCK_LEN), .BLOCKS(BLOCKS)) u_pos (
    .clk        (clk),
    .rst        (rst),
    .frame_start(rx_frame_start),
    .active     (active),
    .at_ovh     (at_ovh),
    .at_start   (at_start)
  );

  // The requested format applies from the boundary on.
  assign fmt_now = at_start ? out_fmt_e'(mode_sel) : mode_q;

  always_ff @(posedge clk) begin
    if (rst)           mode_q <= FMT_SERIAL;
    else if (at_start) mode_q <= out_fmt_e'(mode_sel);
  end

  ds3po_serial_path u_ser (
    .clk     (clk),
    .rst     (rst),
    .active  (active),
    .fmt_nib (fmt_now == FMT_NIBBLE),
    .at_ovh  (at_ovh),
    .at_start(at_start),
    .din     (rx_bit),
    .ser_data(ser_data),
    .ser_ovh (ser_ovh),
    .ser_frm (ser_frm)
  );

  ds3po_nibble_pack #(.NIB_W(NIB_W)) u_nib (
    .clk     (clk),
    .rst     (rst),
    .active  (active),
    .fmt_nib (fmt_now == FMT_NIBBLE),
    .at_ovh  (at_ovh),
    .at_start(at_start),
    .din     (rx_bit),
    .nib_data(nib_data),
    .nib_clk (nib_clk),
    .nib_frm (nib_frm)
  );

  // Only one of the two sources can be set in a given cycle.
  assign frame_mark = ser_frm | nib_frm;
endmodule

module ds3po_rx_out_chk #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             ser_data,
  input logic             ser_ovh,
  input logic [NIB_W-1:0] nib_data,
  input logic             nib_clk,
  input logic             frame_mark,
  input logic             mode_q,
  input logic             at_start
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R8: the cycle after a reset edge shows all outputs cleared.
  always @(posedge clk) begin
    if (rst_d === 1'b1 && !rst) begin
      p_reset_quiet_r8: assert (!ser_data && !ser_ovh && nib_data == '0
                                && !nib_clk && !frame_mark);
    end
  end

  // R5: each nibble clock pulse lasts one clock.
  p_nclk_single_r5: assert property (@(posedge clk) disable iff (rst)
    nib_clk |=> !nib_clk);

  // R5: pulses are at least four clocks apart.
  p_nclk_spacing_r5: assert property (@(posedge clk) disable iff (rst)
    nib_clk |-> (!$past(nib_clk, 1) && !$past(nib_clk, 2) && !$past(nib_clk, 3)));

  // R5: the word is already stable when the nibble clock is high.
  p_nclk_data_stable_r5: assert property (@(posedge clk) disable iff (rst)
    nib_clk |-> $stable(nib_data));

  // R3: in serial format the frame mark coincides with an overhead bit.
  p_frame_on_ovh_r3: assert property (@(posedge clk) disable iff (rst)
    (frame_mark && !mode_q) |-> ser_ovh);

  // R7: the active format changes only after a frame boundary.
  p_mode_at_boundary_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |-> $past(at_start));
endmodule

bind ds3po_rx_out ds3po_rx_out_chk #(.NIB_W(NIB_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ser_data  (ser_data),
  .ser_ovh   (ser_ovh),
  .nib_data  (nib_data),
  .nib_clk   (nib_clk),
  .frame_mark(frame_mark),
  .mode_q    (mode_q),
  .at_start  (at_start)
);

// File: tb/tb_ds3po_rx_out.sv
module tb_ds3po_rx_out;
  localparam int FRAME = 4760;
  localparam int BLK   = 85;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_sel = 1'b0;
  logic       rx_bit = 1'b0;
  logic       rx_frame_start = 1'b0;
  logic       ser_data, ser_ovh, nib_clk, frame_mark;
  logic [3:0] nib_data;

  ds3po_rx_out dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .rx_bit(rx_bit),
    .rx_frame_start(rx_frame_start), .ser_data(ser_data), .ser_ovh(ser_ovh),
    .nib_data(nib_data), .nib_clk(nib_clk), .frame_mark(frame_mark)
  );

  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Stimulus controls set by the sequence below.
  bit ctl_rst = 1, ctl_mode = 0, ctl_fs_en = 0, ctl_auto = 1, force_fs = 0;

  // Reference model state.
  bit m_sync, m_mode, m_first, m_pend;
  int m_pos, m_ph, m_sh;
  bit e_ser, e_ovh, e_nclk, e_frm, e_mode, e_sync;
  int e_nd;

  // Frame statistics gathered from sampled outputs.
  bit have_mark = 0, disturb = 0, fs_in = 0, prev_frm = 0;
  int marks = 0, gap = 0, pulses = 0, pul_total = 0;

  task automatic model_step(bit r, bit b, bit fs, bit msel);
    bit at0, ov, em, npend;
    int p;
    if (r) begin
      m_sync = 0; m_mode = 0; m_first = 0; m_pend = 0; m_pos = 0; m_ph = 0; m_sh = 0;
      e_ser = 0; e_ovh = 0; e_nclk = 0; e_frm = 0; e_nd = 0; e_mode = 0; e_sync = 0;
    end else if (m_sync || fs) begin
      p = fs ? 0 : m_pos;
      at0 = (p == 0);
      ov = (p % BLK == 0);
      em = at0 ? msel : m_mode;
      e_nclk = m_pend;
      npend = 0;
      if (!em) begin
        e_ser = b; e_ovh = ov; e_frm = at0;
        if (!m_pend) e_nd = 0;
      end else begin
        e_ser = 0; e_ovh = 0;
        if (ov) begin
          m_ph = 0;
          if (at0) m_first = 1;
        end else begin
          if (m_ph == 3) begin
            e_nd = ((m_sh << 1) | int'(b)) & 15;
            npend = 1; e_frm = m_first; m_first = 0; m_ph = 0;
          end else m_ph++;
          m_sh = ((m_sh << 1) | int'(b)) & 7;
        end
      end
      m_pend = npend; m_mode = em; m_sync = 1; e_sync = 1;
      e_mode = em;
      m_pos = (p + 1) % FRAME;
    end
  endtask

  always @(negedge clk) begin
    bit nb, nfs;
    string t;
    // Compare outputs registered at the preceding rising edge.
    if (!e_sync) t = "R8";
    chk(!e_sync ? "R8 ser_data" : (e_mode ? "R11 ser_data" : "R1 ser_data"), int'(ser_data), int'(e_ser));
    chk(!e_sync ? "R8 ser_ovh" : (e_mode ? "R11 ser_ovh" : "R2 ser_ovh"), int'(ser_ovh), int'(e_ovh));
    chk(!e_sync ? "R8 nib_data" : (e_mode ? "R4 nib_data" : "R11 nib_data"), int'(nib_data), e_nd);
    chk(!e_sync ? "R8 nib_clk" : "R5 nib_clk", int'(nib_clk), int'(e_nclk));
    chk(!e_sync ? "R8 frame_mark" : (e_mode ? "R6 frame_mark" : "R3 frame_mark"), int'(frame_mark), int'(e_frm));
    // Frame period and pulse count between successive mark rises.
    if (frame_mark && !prev_frm) begin
      if (have_mark && !disturb) begin
        chk(fs_in ? "R9 period with frame start" : "R10 free-running period", gap, FRAME);
        if (e_mode) chk("R5 nibble pulses per frame", pulses, 1176);
      end
      have_mark = 1; disturb = 0; fs_in = 0; gap = 0; pulses = 0;
      marks++;
    end
    prev_frm = frame_mark;
    gap++;
    if (nib_clk) begin pulses++; pul_total++; end
    // Next stimulus.
    nb = 1'($urandom & 1);
    nfs = ctl_fs_en && !ctl_rst && ((ctl_auto && m_pos == 0) || force_fs);
    if (force_fs) disturb = 1;
    force_fs = 0;
    if (nfs) fs_in = 1;
    if (ctl_rst) begin have_mark = 0; disturb = 0; end
    model_step(ctl_rst, nb, nfs, ctl_mode);
    rst = ctl_rst; rx_bit = nb; rx_frame_start = nfs; mode_sel = ctl_mode;
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_marks(int n);
    int target = marks + n;
    while (marks < target) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int p0;
    void'($urandom(32'd20240611));
    wait_cyc(5);
    ctl_rst = 0;
    wait_cyc(20);
    #1;
    // R8: still unsynchronised, everything quiet.
    chk("R8 quiet before frame start", int'({ser_data, ser_ovh, nib_data, nib_clk, frame_mark}), 0);
    ctl_fs_en = 1;
    wait_marks(3);
    // R7: mid-frame request for nibble format waits for the boundary.
    wait_cyc(1000);
    p0 = pul_total;
    ctl_mode = 1; disturb = 1;
    wait_marks(1);
    chk("R7 no nibble clock before boundary", pul_total - p0, 0);
    wait_marks(4);
    // R9: resynchronise in the middle of a nibble frame.
    wait_cyc(777);
    force_fs = 1;
    wait_marks(2);
    ctl_mode = 0; disturb = 1;
    wait_marks(2);
    // R9: mid-frame frame start in serial format marks the next output.
    wait_cyc(1234);
    @(posedge clk);
    force_fs = 1;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk("R9 frame mark after resync", int'(frame_mark), 1);
    chk("R9 overhead flag after resync", int'(ser_ovh), 1);
    wait_marks(1);
    // R10: free-running counter in both formats.
    ctl_auto = 0;
    wait_marks(4);
    ctl_mode = 1; disturb = 1;
    wait_marks(3);
    // R8: reset in mid-run, then restart.
    ctl_rst = 1;
    wait_cyc(3);
    #1;
    chk("R8 outputs during reset", int'({ser_data, ser_ovh, nib_data, nib_clk, frame_mark}), 0);
    ctl_rst = 0; ctl_auto = 1;
    wait_marks(3);
    finish_run();
  end
endmodule